// File: doc/BRIEF.md
# Bidirectional Handshake Port Controller

This block runs one 8-bit peripheral port as a two-way channel. The same pins carry data in both directions, and two handshake pairs control the traffic. For outbound data, the host writes a byte into an output latch. A "buffer full" line then goes low to tell the peripheral. The peripheral pulls its acknowledge line low, which turns on the pin driver so it presents the byte. For inbound data, the peripheral places a byte on the pins and pulls its strobe line low. That captures the byte into a separate input latch and raises an "input full" flag. A later host read of the port clears the flag.

Each direction has its own interrupt-enable flag. The host sets or clears these flags with single-bit set/reset commands that use fixed bit indices. The two masked conditions are ORed into one interrupt request. An 8-bit status word collects the handshake lines, the enable flags and the interrupt, so that the host can poll instead of waiting for the interrupt. The three low status bits come from a neighbouring group and pass straight through.

The host side is synchronous to `clk`. A host access is a level that is high for one or more cycles, and the block detects its start and its end internally. The pin driver appears as a data output plus an output-enable, so a pad or a tri-state buffer can sit outside the block. All outputs are registered.

Top module: `bidir_hs_port`

## Requirements
- R1: While `rst` is high and on the first cycle after it: `obf_n`=1, `ibf`=0, `intr`=0, `pa_oe`=0, both enable flags are 0, and both latches are 0.
- R2: While `wr_a` is high, `wr_data` is loaded into the output latch, which `pa_out` presents. On the clock edge at which `wr_a` is first seen low after being high, `obf_n` goes low. A second write while `obf_n` is still low replaces the latched data, and `obf_n` stays low.
- R3: `pa_oe` is 1 in the cycle after `ack_n` is sampled low and 0 in the cycle after `ack_n` is sampled high. `pa_out` keeps showing the latched byte.
- R4: Sampling `ack_n` low drives `obf_n` high. If a write ends on the same edge, the write wins and `obf_n` goes low.
- R5: Sampling `stb_n` low copies `pa_in` into the input latch, which `rd_data` presents, and sets `ibf`. The edge that ends a read (`rd_a` seen low after high) clears `ibf`, unless `stb_n` is low on that same edge.
- R6: A command with `bsr_en`=1 and `bsr_idx`=6 loads `bsr_val` into the output enable flag. With `bsr_idx`=4 it loads the input enable flag. Any other index changes neither flag.
- R7: `intr` is registered. It becomes 1 when (`obf_n`=1 and `ack_n`=1 and output enable=1) or (`ibf`=1 and `stb_n`=1 and input enable=1). It is forced to 0 while `rd_a` or `wr_a` is high and on the edge that ends either access.
- R8: `status` = {`obf_n`, output enable, `ibf`, input enable, `intr`, `grpb_bits` registered one cycle}. Bit 7 is the MSB.
- R9: While `stb_n` stays high, changes on `pa_in` do not reach `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_a | input | 1 | Host write of the port is in progress (level) |
| wr_data | input | 8 | Host write data |
| rd_a | input | 1 | Host read of the port is in progress (level) |
| rd_data | output | 8 | Input latch contents |
| bsr_en | input | 1 | Single-bit set/reset command valid |
| bsr_idx | input | 3 | Bit index of the command |
| bsr_val | input | 1 | Value to load: 1 sets, 0 clears |
| grpb_bits | input | 3 | Neighbour group status bits |
| status | output | 8 | Status word |
| pa_in | input | 8 | Sampled pin data |
| pa_out | output | 8 | Output latch to the pin driver |
| pa_oe | output | 1 | Pin driver enable |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| obf_n | output | 1 | Output buffer full, active low |
| ibf | output | 1 | Input buffer full |
| intr | output | 1 | Combined interrupt request |

## Verification
The hardest cases to reach are the ones where two events fall on the same edge: a write that ends on the edge where acknowledge arrives, and a strobe on the edge where a read ends. In both, the "set" must win over the "clear". The stimulus lines up these edges by dropping the access level in the same cycle that it lowers the handshake line. Checking that each interrupt source works alone is also delicate, so the bench masks one enable flag while it drives the other direction.

// File: rtl/bidir_hs_pkg.sv
package bidir_hs_pkg;
  localparam int DATA_W   = 8;
  localparam int IDX_W    = 3;
  localparam int GRPB_W   = 3;
  localparam int STAT_W   = 8;
  localparam int OUT_EN_IDX = 6;
  localparam int IN_EN_IDX  = 4;

  typedef struct packed {
    logic              obf_n;
    logic              inte_out;
    logic              ibf;
    logic              inte_in;
    logic              intr;
    logic [GRPB_W-1:0] grpb;
  } status_t;
endpackage

// File: rtl/hs_out_side.sv
module hs_out_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_a,
  input  logic [DW-1:0] wr_data,
  input  logic          ack_n,
  output logic [DW-1:0] out_q,
  output logic          obf_n,
  output logic          pa_oe,
  output logic          wr_hold
);
  logic wr_d;
  logic wr_end;

  assign wr_end  = wr_d & ~wr_a;
  assign wr_hold = wr_a | wr_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_d  <= 1'b0;
      out_q <= '0;
      obf_n <= 1'b1;
      pa_oe <= 1'b0;
    end else begin
      wr_d  <= wr_a;
      pa_oe <= ~ack_n;
      if (wr_a) out_q <= wr_data;
      if (wr_end)      obf_n <= 1'b0;
      else if (!ack_n) obf_n <= 1'b1;
    end
  end

  // R2
  wr_sets_full_chk: assert property (@(posedge clk) disable iff (rst)
    wr_end |=> !obf_n);
  // R4
  ack_empties_chk: assert property (@(posedge clk) disable iff (rst)
    (!ack_n && !wr_end) |=> obf_n);
  // R3
  oe_follows_ack_chk: assert property (@(posedge clk) disable iff (rst)
    !ack_n |=> pa_oe);
  // R3
  oe_off_chk: assert property (@(posedge clk) disable iff (rst)
    ack_n |=> !pa_oe);
endmodule

// File: rtl/hs_in_side.sv
module hs_in_side #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb_n,
  input  logic [DW-1:0] pa_in,
  input  logic          rd_a,
  output logic [DW-1:0] in_q,
  output logic          ibf,
  output logic          rd_hold
);
  logic rd_d;
  logic rd_end;

  assign rd_end  = rd_d & ~rd_a;
  assign rd_hold = rd_a | rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_d <= 1'b0;
      in_q <= '0;
      ibf  <= 1'b0;
    end else begin
      rd_d <= rd_a;
      if (!stb_n) begin
        in_q <= pa_in;
        ibf  <= 1'b1;
      end else if (rd_end) begin
        ibf  <= 1'b0;
      end
    end
  end

  // R5
  stb_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !stb_n |=> (ibf && in_q == $past(pa_in)));
  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    stb_n |=> $stable(in_q));
endmodule

// File: rtl/hs_irq_ctl.sv
module hs_irq_ctl #(
  parameter int IW      = 3,
  parameter int OUT_IDX = 6,
  parameter int IN_IDX  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bsr_en,
  input  logic [IW-1:0] bsr_idx,
  input  logic          bsr_val,
  input  logic          obf_n,
  input  logic          ack_n,
  input  logic          ibf,
  input  logic          stb_n,
  input  logic          clr,
  output logic          inte_out,
  output logic          inte_in,
  output logic          intr
);
  localparam logic [IW-1:0] OUT_SEL = IW'(OUT_IDX);
  localparam logic [IW-1:0] IN_SEL  = IW'(IN_IDX);

  logic out_term;
  logic in_term;

  assign out_term = obf_n & ack_n & inte_out;
  assign in_term  = ibf & stb_n & inte_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      inte_out <= 1'b0;
      inte_in  <= 1'b0;
      intr     <= 1'b0;
    end else begin
      if (bsr_en && bsr_idx == OUT_SEL) inte_out <= bsr_val;
      if (bsr_en && bsr_idx == IN_SEL)  inte_in  <= bsr_val;
      intr <= ~clr & (out_term | in_term);
    end
  end

  // R6
  other_idx_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bsr_en && bsr_idx != OUT_SEL && bsr_idx != IN_SEL) |=>
      ($stable(inte_out) && $stable(inte_in)));
  // R7
  access_clears_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> !intr);
  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!inte_out && !inte_in && !bsr_en) |=> !intr);
endmodule

// File: rtl/bidir_hs_port.sv
module bidir_hs_port
  import bidir_hs_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_a,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_a,
  output logic [DW-1:0]     rd_data,
  input  logic              bsr_en,
  input  logic [IDX_W-1:0]  bsr_idx,
  input  logic              bsr_val,
  input  logic [GRPB_W-1:0] grpb_bits,
  output logic [STAT_W-1:0] status,
  input  logic [DW-1:0]     pa_in,
  output logic [DW-1:0]     pa_out,
  output logic              pa_oe,
  input  logic              ack_n,
  input  logic              stb_n,
  output logic              obf_n,
  output logic              ibf,
  output logic              intr
);
  logic              wr_hold;
  logic              rd_hold;
  logic              inte_out;
  logic              inte_in;
  logic [GRPB_W-1:0] grpb_q;
  status_t           st;

  hs_out_side #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .wr_a(wr_a), .wr_data(wr_data), .ack_n(ack_n),
    .out_q(pa_out), .obf_n(obf_n), .pa_oe(pa_oe), .wr_hold(wr_hold)
  );

  hs_in_side #(.DW(DW)) u_in (
    .clk(clk), .rst(rst), .stb_n(stb_n), .pa_in(pa_in), .rd_a(rd_a),
    .in_q(rd_data), .ibf(ibf), .rd_hold(rd_hold)
  );

  hs_irq_ctl #(.IW(IDX_W), .OUT_IDX(OUT_EN_IDX), .IN_IDX(IN_EN_IDX)) u_irq (
    .clk(clk), .rst(rst), .bsr_en(bsr_en), .bsr_idx(bsr_idx),
    .bsr_val(bsr_val), .obf_n(obf_n), .ack_n(ack_n), .ibf(ibf),
    .stb_n(stb_n), .clr(wr_hold | rd_hold), .inte_out(inte_out),
    .inte_in(inte_in), .intr(intr)
  );

  always_ff @(posedge clk) begin
    if (rst) grpb_q <= '0;
    else     grpb_q <= grpb_bits;
  end

  always_comb begin
    st.obf_n    = obf_n;
    st.inte_out = inte_out;
    st.ibf      = ibf;
    st.inte_in  = inte_in;
    st.intr     = intr;
    st.grpb     = grpb_q;
  end
  assign status = st;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (obf_n && !ibf && !intr && !pa_oe && !inte_out && !inte_in));
endmodule

// File: tb/bidir_hs_port_bench.sv
module bidir_hs_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_a = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_a = 1'b0;
  logic [7:0] rd_data;
  logic       bsr_en = 1'b0;
  logic [2:0] bsr_idx = '0;
  logic       bsr_val = 1'b0;
  logic [2:0] grpb_bits = 3'b101;
  logic [7:0] status;
  logic [7:0] pa_in = '0;
  logic [7:0] pa_out;
  logic       pa_oe;
  logic       ack_n = 1'b1;
  logic       stb_n = 1'b1;
  logic       obf_n;
  logic       ibf;
  logic       intr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string tag;
    int    sel;
    logic [7:0] exp;
  } item_t;
  item_t q[$];

  always #5 clk = ~clk;

  bidir_hs_port u_bidir_hs_port (
    .clk(clk), .rst(rst), .wr_a(wr_a), .wr_data(wr_data), .rd_a(rd_a),
    .rd_data(rd_data), .bsr_en(bsr_en), .bsr_idx(bsr_idx),
    .bsr_val(bsr_val), .grpb_bits(grpb_bits), .status(status),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .ack_n(ack_n),
    .stb_n(stb_n), .obf_n(obf_n), .ibf(ibf), .intr(intr)
  );

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: pick = {7'd0, obf_n};
      1: pick = {7'd0, ibf};
      2: pick = {7'd0, intr};
      3: pick = {7'd0, pa_oe};
      4: pick = pa_out;
      5: pick = rd_data;
      default: pick = status;
    endcase
  endfunction

  // monitor: compares queued expectations between edges
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        got = pick(it.sel);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic expect_v(int sel, logic [7:0] e, string tag);
    item_t it;
    it.sel = sel; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bsr(logic [2:0] idx, logic v);
    bsr_en = 1'b1; bsr_idx = idx; bsr_val = v;
    step(1);
    bsr_en = 1'b0;
  endtask

  task automatic host_write(logic [7:0] d);
    wr_a = 1'b1; wr_data = d;
    step(1);
    wr_a = 1'b0;
    step(1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_v(0, 8'd1, "R1 obf_n in reset");
    rst = 1'b0;
    step(1);
    expect_v(0, 8'd1, "R1 obf_n");
    expect_v(1, 8'd0, "R1 ibf");
    expect_v(2, 8'd0, "R1 intr");
    expect_v(3, 8'd0, "R1 pa_oe");
    expect_v(6, 8'h85, "R1 R8 status after reset");

    bsr(3'd6, 1'b1);
    step(1);
    expect_v(2, 8'd1, "R7 intr from empty output side");
    expect_v(6, 8'hCD, "R6 R8 output enable set");
    bsr(3'd5, 1'b1);
    expect_v(6, 8'hCD, "R6 other index ignored");
    bsr(3'd4, 1'b1);
    step(1);
    expect_v(6, 8'hDD, "R6 input enable set");

    wr_a = 1'b1; wr_data = 8'h3C;
    step(1);
    expect_v(2, 8'd0, "R7 intr cleared by write");
    wr_a = 1'b0;
    step(1);
    expect_v(0, 8'd0, "R2 obf_n low after write");
    expect_v(4, 8'h3C, "R2 latched data");
    step(1);
    expect_v(2, 8'd0, "R7 no intr while full");
    expect_v(3, 8'd0, "R3 driver off without ack");

    host_write(8'hA5);
    expect_v(0, 8'd0, "R2 overwrite keeps full");
    expect_v(4, 8'hA5, "R2 overwrite data");

    ack_n = 1'b0;
    step(1);
    expect_v(3, 8'd1, "R3 driver on with ack");
    expect_v(0, 8'd1, "R4 ack empties");
    expect_v(4, 8'hA5, "R3 driven data");
    expect_v(2, 8'd0, "R7 no intr while ack low");
    ack_n = 1'b1;
    step(1);
    expect_v(3, 8'd0, "R3 driver off after ack");
    expect_v(2, 8'd1, "R7 intr after ack release");

    wr_a = 1'b1; wr_data = 8'h11;
    step(1);
    wr_a = 1'b0; ack_n = 1'b0;
    step(1);
    expect_v(0, 8'd0, "R4 write end wins over ack");
    ack_n = 1'b1;
    step(1);
    ack_n = 1'b0;
    step(1);
    expect_v(0, 8'd1, "R4 later ack empties");
    ack_n = 1'b1;

    bsr(3'd6, 1'b0);
    step(1);
    expect_v(2, 8'd0, "R7 R6 output term masked");

    pa_in = 8'h5A; stb_n = 1'b0;
    step(1);
    expect_v(1, 8'd1, "R5 strobe sets ibf");
    expect_v(5, 8'h5A, "R5 captured data");
    pa_in = 8'h77; stb_n = 1'b1;
    step(1);
    expect_v(5, 8'h5A, "R9 latch holds while strobe high");
    expect_v(2, 8'd1, "R7 input term");
    expect_v(6, 8'hBD, "R8 status with input full");

    rd_a = 1'b1;
    step(1);
    expect_v(2, 8'd0, "R7 intr cleared by read");
    expect_v(1, 8'd1, "R5 ibf held during read");
    rd_a = 1'b0;
    step(1);
    expect_v(1, 8'd0, "R5 read end clears ibf");
    step(1);
    expect_v(2, 8'd0, "R7 no intr after read");

    rd_a = 1'b1;
    step(1);
    rd_a = 1'b0; stb_n = 1'b0; pa_in = 8'hC3;
    step(1);
    expect_v(1, 8'd1, "R5 strobe wins over read end");
    expect_v(5, 8'hC3, "R5 new capture");
    stb_n = 1'b1;

    grpb_bits = 3'b010;
    bsr(3'd4, 1'b0);
    step(1);
    expect_v(6, 8'hA2, "R8 R6 status after input enable cleared");
    expect_v(2, 8'd0, "R7 intr masked");

    step(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule